// File: doc/BRIEF.md
# Carry-Chained Execute Unit with Bitfield Operations

This block is the execute stage of a small command-processing sequencer. Each cycle it takes an operation select, two 32-bit register operands, a sign-extended immediate and three 5-bit bitfield controls. It returns a 32-bit result from purely combinational logic. The arithmetic family shares one carry flag, held in a register. Add and subtract can therefore be chained across several instructions to build wider arithmetic. After a subtract, the flag means "no borrow occurred".

The surrounding sequencer owns the register file, the program counter and the routing of results. It raises `exec_valid` on each cycle that retires an instruction, so that the carry flag is committed only on those cycles. It pulses `macro_start` when a new command sequence begins, which clears the flag. Three bitfield forms are provided: insert a field into operand A, and two extract-and-shift forms that take one of their two shift amounts from the low bits of operand A.

Top module: `ucalu_top`

## Requirements
- R1: Operation code 0 (add) gives A+B modulo 2^32. `carry_next` is 1 exactly when the true sum exceeds 0xFFFFFFFF.
- R2: Operation code 1 (add with carry) gives A+B+cin modulo 2^32, with the same carry rule as R1. Here cin is the carry flag seen this cycle.
- R3: Operation code 2 (subtract) gives A−B modulo 2^32. `carry_next` is 1 exactly when A ≥ B as unsigned values (no borrow).
- R4: Operation code 3 (subtract with borrow) gives A−B−(1−cin) modulo 2^32. `carry_next` is 1 exactly when this difference is not negative.
- R5: Operation codes 4 to 8 give A XOR B, A OR B, A AND B, A AND NOT B and NOT(A AND B), in that order. They pass the incoming carry through unchanged.
- R6: Operation code 9 (add immediate) gives A plus the 18-bit immediate sign-extended to 32 bits. The carry is left unchanged.
- R7: Operation code 10 (insert) takes the `bf_width`-bit field of B that starts at bit `bf_src` and writes it into A starting at bit `bf_dst`. Bits that fall above bit 31 are dropped, and all other bits of A are kept.
- R8: Operation code 11 shifts B right by A[4:0], keeps the low `bf_width` bits, then shifts the kept bits left by `bf_dst`.
- R9: Operation code 12 shifts B right by `bf_src`, keeps the low `bf_width` bits, then shifts the kept bits left by A[4:0].
- R10: The field mask is (1<<`bf_width`)−1, so a width of 0 gives a zero field. Shift amounts taken from A use only A[4:0], and the upper bits of A have no effect on them.
- R11: A cycle with `macro_start`=1 sees a carry flag of 0. With `exec_valid`=0, `carry_q` is 0 after the clock edge.
- R12: Operation codes 13 to 15 give a result of 0 and pass the incoming carry through unchanged.
- R13: `carry_q` is 0 after reset. It takes `carry_next` at a clock edge only when `exec_valid` is 1, and otherwise holds its value (apart from the clear in R11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| macro_start | input | 1 | First cycle of a command sequence; clears the carry flag |
| exec_valid | input | 1 | Commit `carry_next` into `carry_q` at this edge |
| op_sel | input | 4 | Operation select (codes listed in R1 to R12) |
| opnd_a | input | 32 | Register operand A |
| opnd_b | input | 32 | Register operand B |
| imm | input | 18 | Signed immediate |
| bf_src | input | 5 | Bitfield source bit position |
| bf_dst | input | 5 | Bitfield destination bit position |
| bf_width | input | 5 | Bitfield width |
| result | output | 32 | Combinational result |
| carry_next | output | 1 | Updated carry for this operation |
| carry_q | output | 1 | Registered carry flag |

## Verification
The assertions check several properties on every cycle:
- Add overflow agrees with the wrapped sum falling below A.
- The subtract flag agrees with the unsigned comparison A ≥ B.
- Insert leaves every bit of A outside the destination field intact.
- Undefined codes give zero.
- Logic operations and idle cycles leave the flag where it was.
- A start with no commit leaves the flag clear.

Only the bench scenarios show the exact chained values of multi-word add and subtract sequences. They also show the bit-exact outputs of the two extract-and-shift forms for chosen fields, the empty field at width 0, and the masking of register shift amounts to five bits.

// File: rtl/ucalu_pkg.sv
package ucalu_pkg;
  localparam int DATA_W = 32;
  localparam int SH_W   = $clog2(DATA_W);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [SH_W-1:0]   shamt_t;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBB  = 4'd3,
    OP_XOR   = 4'd4,
    OP_OR    = 4'd5,
    OP_AND   = 4'd6,
    OP_ANDN  = 4'd7,
    OP_NAND  = 4'd8,
    OP_ADDI  = 4'd9,
    OP_BFINS = 4'd10,
    OP_BFSLI = 4'd11,
    OP_BFSLR = 4'd12
  } op_e;

  // Low-bit mask of the given width; width 0 yields an empty mask.
  function automatic word_t field_mask(shamt_t w);
    return (word_t'(1) << w) - word_t'(1);
  endfunction

  // One adder for the whole add/subtract family; bit DATA_W is the carry out.
  function automatic logic [DATA_W:0] add_cin(word_t a, word_t b, logic cin);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
  endfunction

  // Take a field of val at rshift, mask to w bits, place it at lshift.
  function automatic word_t extract_place(word_t val, shamt_t rshift,
                                          shamt_t lshift, shamt_t w);
    return ((val >> rshift) & field_mask(w)) << lshift;
  endfunction

  // Overwrite a field of base at dst with the field of src at sbit.
  function automatic word_t insert_field(word_t base, word_t src, shamt_t sbit,
                                         shamt_t dst, shamt_t w);
    return (base & ~(field_mask(w) << dst)) | extract_place(src, sbit, dst, w);
  endfunction
endpackage

// File: rtl/ucalu_arith.sv
module ucalu_arith
  import ucalu_pkg::*;
(
  input  word_t a,
  input  word_t b,
  input  logic  invert_b,
  input  logic  cin,
  output word_t sum,
  output logic  cout
);
  logic [DATA_W:0] wide;
  word_t           b_eff;

  // A - B - borrow is formed as A + ~B + carry; the carry out is "no borrow".
  assign b_eff = invert_b ? ~b : b;
  assign wide  = add_cin(a, b_eff, cin);
  assign sum   = wide[DATA_W-1:0];
  assign cout  = wide[DATA_W];
endmodule

// File: rtl/ucalu_logic.sv
module ucalu_logic
  import ucalu_pkg::*;
(
  input  logic [3:0] op,
  input  word_t      a,
  input  word_t      b,
  output word_t      res
);
  always_comb begin
    case (op)
      OP_XOR:  res = a ^ b;
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_ANDN: res = a & ~b;
      OP_NAND: res = ~(a & b);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/ucalu_bitfield.sv
module ucalu_bitfield
  import ucalu_pkg::*;
(
  input  word_t  a,
  input  word_t  b,
  input  shamt_t src_bit,
  input  shamt_t dst_bit,
  input  shamt_t width,
  output word_t  ins_res,
  output word_t  sli_res,
  output word_t  slr_res
);
  shamt_t a_shamt;

  // Register-sourced shift amounts use only the low bits of A.
  assign a_shamt = a[SH_W-1:0];

  assign ins_res = insert_field(a, b, src_bit, dst_bit, width);
  assign sli_res = extract_place(b, a_shamt, dst_bit, width);
  assign slr_res = extract_place(b, src_bit, a_shamt, width);
endmodule

// File: rtl/ucalu_top.sv
module ucalu_top
  import ucalu_pkg::*;
#(
  parameter int IMM_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              macro_start,
  input  logic              exec_valid,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   bf_src,
  input  logic [SH_W-1:0]   bf_dst,
  input  logic [SH_W-1:0]   bf_width,
  output logic [DATA_W-1:0] result,
  output logic              carry_next,
  output logic              carry_q
);
  localparam int EXT_W = DATA_W - IMM_W;

  // Named internal events, kept visible for the assertions.
  logic  carry_in;
  logic  op_is_arith;
  logic  op_is_logic;
  logic  op_undef;
  logic  op_sub;
  logic  op_chain;
  logic  arith_cin;
  word_t arith_sum;
  logic  arith_cout;
  word_t logic_res;
  word_t ins_res, sli_res, slr_res;
  word_t imm_ext;
  word_t bf_keep_mask;

  assign carry_in    = macro_start ? 1'b0 : carry_q;
  assign op_is_arith = (op_sel <= 4'(OP_SUBB));
  assign op_is_logic = (op_sel >= 4'(OP_XOR)) && (op_sel <= 4'(OP_NAND));
  assign op_undef    = (op_sel > 4'(OP_BFSLR));
  assign op_sub      = (op_sel == 4'(OP_SUB)) || (op_sel == 4'(OP_SUBB));
  assign op_chain    = (op_sel == 4'(OP_ADDC)) || (op_sel == 4'(OP_SUBB));
  assign arith_cin   = op_chain ? carry_in : op_sub;
  assign imm_ext     = {{EXT_W{imm[IMM_W-1]}}, imm};

  ucalu_arith u_arith (
    .a        (opnd_a),
    .b        (opnd_b),
    .invert_b (op_sub),
    .cin      (arith_cin),
    .sum      (arith_sum),
    .cout     (arith_cout)
  );

  ucalu_logic u_logic (
    .op  (op_sel),
    .a   (opnd_a),
    .b   (opnd_b),
    .res (logic_res)
  );

  ucalu_bitfield u_bitfield (
    .a       (opnd_a),
    .b       (opnd_b),
    .src_bit (bf_src),
    .dst_bit (bf_dst),
    .width   (bf_width),
    .ins_res (ins_res),
    .sli_res (sli_res),
    .slr_res (slr_res)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB:           result = arith_sum;
      OP_XOR, OP_OR, OP_AND, OP_ANDN, OP_NAND:    result = logic_res;
      OP_ADDI:                                    result = opnd_a + imm_ext;
      OP_BFINS:                                   result = ins_res;
      OP_BFSLI:                                   result = sli_res;
      OP_BFSLR:                                   result = slr_res;
      default:                                    result = '0;
    endcase
  end

  assign carry_next = op_is_arith ? arith_cout : carry_in;

  always_ff @(posedge clk) begin
    if (!rst_n)           carry_q <= 1'b0;
    else if (exec_valid)  carry_q <= carry_next;
    else if (macro_start) carry_q <= 1'b0;
  end

  // Bits of A that an insert must leave alone, derived by a loop here
  // rather than through the bitfield unit's mask function.
  always_comb begin
    bf_keep_mask = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if ((i >= int'(bf_dst)) && (i < int'(bf_dst) + int'(bf_width)))
        bf_keep_mask[i] = 1'b0;
    end
  end

  // ---------------- assertions ----------------
  assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'(OP_ADD)) |-> (carry_next == (result < opnd_a)));

  assert_sub_noborrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'(OP_SUB)) |-> ((carry_next == (opnd_a >= opnd_b)) &&
                                 (result == opnd_a - opnd_b)));

  assert_logic_keeps_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && op_is_logic && !macro_start) |=> (carry_q == $past(carry_q)));

  assert_insert_keeps_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'(OP_BFINS)) |-> (((result ^ opnd_a) & bf_keep_mask) == '0));

  assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (macro_start && !exec_valid) |=> !carry_q);

  assert_undef_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    op_undef |-> ((result == '0) && (carry_next == carry_in)));

  assert_idle_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_valid && !macro_start) |=> $stable(carry_q));
endmodule

// File: tb/ucalu_top_tb_top.sv
`timescale 1ns/1ps
module ucalu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        macro_start = 1'b0;
  logic        exec_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [17:0] imm = '0;
  logic [4:0]  bf_src = '0;
  logic [4:0]  bf_dst = '0;
  logic [4:0]  bf_width = '0;
  logic [31:0] result;
  logic        carry_next;
  logic        carry_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit model_c  = 1'b0;

  always #2 clk = ~clk;

  ucalu_top dut_i (
    .clk(clk), .rst_n(rst_n), .macro_start(macro_start), .exec_valid(exec_valid),
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
    .bf_src(bf_src), .bf_dst(bf_dst), .bf_width(bf_width),
    .result(result), .carry_next(carry_next), .carry_q(carry_q)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Place the field of src (from sbit, w bits) at dbit, bit by bit.
  function automatic logic [31:0] place_bits(logic [31:0] src, int sbit, int dbit, int w);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++)
      if (dbit + i < 32 && sbit + i < 32) r[dbit+i] = src[sbit+i];
    return r;
  endfunction

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [17:0] im, input int s, input int d, input int w,
                       input bit cin, output logic [31:0] res, output bit cout);
    longint unsigned t;
    cout = cin;
    case (op)
      4'd0: begin t = longint'(a) + longint'(b); res = t[31:0]; cout = t > 64'hFFFF_FFFF; end
      4'd1: begin t = longint'(a) + longint'(b) + (cin ? 1 : 0); res = t[31:0]; cout = t > 64'hFFFF_FFFF; end
      4'd2: begin t = longint'(a) - longint'(b); res = t[31:0]; cout = t < 64'h1_0000_0000; end
      4'd3: begin t = longint'(a) - longint'(b) - (cin ? 0 : 1); res = t[31:0]; cout = t < 64'h1_0000_0000; end
      4'd4: res = a ^ b;
      4'd5: res = a | b;
      4'd6: res = a & b;
      4'd7: res = a & ~b;
      4'd8: res = ~(a & b);
      4'd9: res = a + {{14{im[17]}}, im};
      4'd10: begin
        res = a;
        for (int i = 0; i < w; i++) if (d + i < 32) res[d+i] = 1'b0;
        res = res | place_bits(b, s, d, w);
      end
      4'd11: res = place_bits(b, int'(a % 32), d, w);
      4'd12: res = place_bits(b, s, int'(a % 32), w);
      default: res = '0;
    endcase
  endtask

  task automatic run_op(string tag, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                        logic [17:0] im, int s, int d, int w, bit start, bit valid);
    logic [31:0] er;
    bit ec;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; imm = im;
    bf_src = 5'(s); bf_dst = 5'(d); bf_width = 5'(w);
    macro_start = start; exec_valid = valid;
    #1;
    model(op, a, b, im, s, d, w, start ? 1'b0 : model_c, er, ec);
    check(tag, "result", result, er);
    check(tag, "carry_next", 32'(carry_next), 32'(ec));
    @(posedge clk); #1;
    if (valid) model_c = ec; else if (start) model_c = 1'b0;
    check(tag, "carry_q", 32'(carry_q), 32'(model_c));
    macro_start = 1'b0; exec_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R13", "carry_q after reset", 32'(carry_q), 32'd0);
  endtask

  task automatic t_add;
    run_op("R1", 4'd0, 32'h1234_5678, 32'h1111_1111, 0, 0, 0, 0, 1'b0, 1'b1);
    run_op("R1", 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 1'b0, 1'b1);
    run_op("R1", 4'd0, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 1'b0, 1'b1);
  endtask

  task automatic t_addc;
    // 64-bit add 0x00000001_FFFFFFFF + 0x00000002_00000001 in two words
    run_op("R2", 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 1'b0, 1'b1);
    run_op("R2", 4'd1, 32'h0000_0001, 32'h0000_0002, 0, 0, 0, 0, 1'b0, 1'b1);
    run_op("R2", 4'd1, 32'hFFFF_FFFF, 32'h0000_0000, 0, 0, 0, 0, 1'b0, 1'b1);
  endtask

  task automatic t_sub;
    run_op("R3", 4'd2, 32'd10, 32'd3, 0, 0, 0, 0, 1'b0, 1'b1);
    run_op("R3", 4'd2, 32'd3, 32'd10, 0, 0, 0, 0, 1'b0, 1'b1);
    run_op("R3", 4'd2, 32'd7, 32'd7, 0, 0, 0, 0, 1'b0, 1'b1);
  endtask

  task automatic t_subb;
    run_op("R4", 4'd2, 32'd0, 32'd1, 0, 0, 0, 0, 1'b0, 1'b1);   // borrow, carry 0
    run_op("R4", 4'd3, 32'd5, 32'd2, 0, 0, 0, 0, 1'b0, 1'b1);   // 5-2-1=2
    run_op("R4", 4'd3, 32'd5, 32'd5, 0, 0, 0, 0, 1'b0, 1'b1);   // carry 1: 0
    run_op("R4", 4'd3, 32'd0, 32'd0, 0, 0, 0, 0, 1'b0, 1'b1);   // carry 1: 0
  endtask

  task automatic t_logic;
    run_op("R5", 4'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 1'b0, 1'b1); // carry 1
    for (int op = 4; op <= 8; op++)
      run_op("R5", 4'(op), 32'hF0F0_1234, 32'hFF00_5678, 0, 0, 0, 0, 1'b0, 1'b1);
  endtask

  task automatic t_addi;
    run_op("R6", 4'd9, 32'd100, 32'd0, 18'h3FFFF, 0, 0, 0, 1'b0, 1'b1);  // -1
    run_op("R6", 4'd9, 32'hFFFF_FFFF, 32'd0, 18'd2, 0, 0, 0, 1'b0, 1'b1); // wraps, carry kept
  endtask

  task automatic t_bitfield;
    run_op("R7", 4'd10, 32'hFFFF_FFFF, 32'h0000_0A50, 0, 4, 8, 8, 1'b0, 1'b1);
    run_op("R7", 4'd10, 32'h0000_0000, 32'hFFFF_FFFF, 0, 0, 28, 8, 1'b0, 1'b1);
    run_op("R8", 4'd11, 32'd8, 32'hABCD_1234, 0, 0, 4, 12, 1'b0, 1'b1);
    run_op("R9", 4'd12, 32'd16, 32'hABCD_1234, 0, 4, 0, 8, 1'b0, 1'b1);
  endtask

  task automatic t_edges;
    run_op("R10", 4'd10, 32'h1234_5678, 32'hFFFF_FFFF, 0, 3, 5, 0, 1'b0, 1'b1);
    run_op("R10", 4'd11, 32'hFFFF_FF04, 32'h0000_00F0, 0, 0, 0, 4, 1'b0, 1'b1);
    run_op("R10", 4'd12, 32'h0000_0024, 32'h0000_000F, 0, 0, 0, 4, 1'b0, 1'b1);
  endtask

  task automatic t_start;
    run_op("R11", 4'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 1'b0, 1'b1); // carry 1
    run_op("R11", 4'd4, 32'd0, 32'd0, 0, 0, 0, 0, 1'b1, 1'b0);        // start only
    run_op("R11", 4'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 1'b0, 1'b1); // carry 1
    run_op("R11", 4'd1, 32'd5, 32'd6, 0, 0, 0, 0, 1'b1, 1'b1);         // sees 0: 11
  endtask

  task automatic t_undef;
    run_op("R12", 4'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 1'b0, 1'b1);
    for (int op = 13; op <= 15; op++)
      run_op("R12", 4'(op), 32'hDEAD_BEEF, 32'h1234_5678, 18'h155, 1, 2, 3, 1'b0, 1'b1);
  endtask

  task automatic t_hold;
    run_op("R13", 4'd2, 32'd1, 32'd2, 0, 0, 0, 0, 1'b0, 1'b1);        // carry 0
    run_op("R13", 4'd0, 32'hFFFF_FFFF, 32'd9, 0, 0, 0, 0, 1'b0, 1'b0); // not committed
    run_op("R13", 4'd1, 32'd1, 32'd1, 0, 0, 0, 0, 1'b0, 1'b1);        // 1+1+0
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_add();
    t_addc();
    t_sub();
    t_subb();
    t_logic();
    t_addi();
    t_bitfield();
    t_edges();
    t_start();
    t_undef();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule